// File: doc/BRIEF.md
# Dual Wiper Register Bank Controller

This block is the register core of a two-channel digital potentiometer. A 2-wire slave front end hands it commands that are already decoded: an address, an opcode, a channel, a slot index and a 6-bit data value. Each channel keeps one live wiper register, which picks one of 64 taps, and four retained setting registers. The live wiper drives a 64-bit one-hot tap-select vector per channel that feeds the analog switch array.

The retained registers stand in for nonvolatile cells. Any write into them starts a programming window of fixed length, counted in clock cycles. During that window the block refuses every command addressed to it. A write-protect input, active low, blocks only the retained writes and leaves the live wipers writable. Power-up reset loads every retained slot and every wiper with a default setting. A separate recall pulse copies slot 0 of each channel into its wiper and leaves the retained slots as they are.

Top module: `potbank_core`

## Requirements
- R1: After synchronous reset, both wipers and all retained slots hold INIT_SETTING, busy is low, and ack, reject and rd_valid are low.
- R2: A command whose cmd_addr differs from the strap inputs changes no register and raises none of ack, reject or rd_valid.
- R3: Opcode 1 writes cmd_data into the wiper of cmd_chan. Opcode 0 returns that wiper on rd_data, with rd_valid high, in the cycle after the command.
- R4: Opcode 3 writes cmd_data into retained slot cmd_idx of cmd_chan. Opcode 2 returns that slot on rd_data, with rd_valid high, in the cycle after the command.
- R5: While wp_n is low, opcodes 3 and 5 are rejected and leave the slots unchanged. Opcode 1 still updates the wiper.
- R6: Opcode 4 copies slot cmd_idx into the wiper of the same channel. Opcode 5 copies the wiper into slot cmd_idx of the same channel.
- R7: Opcode 6 raises the wiper by one and holds at 63. Opcode 7 lowers it by one and holds at 0.
- R8: An accepted opcode 3 or 5 holds busy high for exactly PROG_CYCLES cycles, starting in the cycle after the command. Every addressed command seen while busy is high is rejected and changes nothing.
- R9: tap_sel has exactly one bit set per channel, at bit ch*64 + wiper.
- R10: A recall pulse loads slot 0 of each channel into its wiper and leaves the slots unchanged. An addressed command in the same cycle is rejected.
- R11: Each addressed command produces, in the next cycle, exactly one of ack (accepted) or reject (refused), each lasting one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| strap | input | 4 | Device address straps |
| wp_n | input | 1 | Retained-write enable; low protects the slots |
| recall | input | 1 | Soft recall pulse, slot 0 to wiper |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_addr | input | 4 | Device address of the command |
| cmd_op | input | 3 | Opcode 0..7 |
| cmd_chan | input | 1 | Channel select |
| cmd_idx | input | 2 | Retained slot index |
| cmd_data | input | 6 | Write data |
| ack | output | 1 | Command accepted (one-cycle pulse) |
| reject | output | 1 | Command refused (one-cycle pulse) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 6 | Read data |
| busy | output | 1 | Programming window active |
| tap_sel | output | 128 | One-hot tap select, channel 1 in the upper 64 bits |

## Verification
Two events can land in the same cycle: a recall pulse together with an addressed command, and the last busy cycle together with a fresh command. The bench drives a wiper write at the same time as recall and expects a reject, with the wiper equal to slot 0 afterwards. It also issues commands on the final busy cycle and on the first free cycle, and expects a reject and then an ack. A behavioural model predicts ack, reject, busy, read data and tap_sel every clock.

// File: rtl/potbank_pkg.sv
package potbank_pkg;

    localparam int TAP_W     = 6;
    localparam int NUM_TAPS  = 1 << TAP_W;
    localparam int NUM_CH    = 2;
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int ADDR_W    = 4;
    localparam int OP_W      = 3;

    typedef logic [TAP_W-1:0] tap_t;

    typedef enum logic [OP_W-1:0] {
        OP_RD_WIPER = 3'd0,
        OP_WR_WIPER = 3'd1,
        OP_RD_SLOT  = 3'd2,
        OP_WR_SLOT  = 3'd3,
        OP_LOAD     = 3'd4,
        OP_STORE    = 3'd5,
        OP_UP       = 3'd6,
        OP_DOWN     = 3'd7
    } op_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        op_e               op;
        logic [CH_W-1:0]   chan;
        logic [SLOT_W-1:0] idx;
        tap_t              data;
    } cmd_t;

    function automatic logic writes_slot(input op_e op);
        return (op == OP_WR_SLOT) || (op == OP_STORE);
    endfunction

    function automatic logic is_read(input op_e op);
        return (op == OP_RD_WIPER) || (op == OP_RD_SLOT);
    endfunction

    function automatic tap_t step_tap(input tap_t cur, input logic up);
        tap_t nxt;
        if (up) nxt = (cur == tap_t'(NUM_TAPS - 1)) ? cur : cur + tap_t'(1);
        else    nxt = (cur == tap_t'(0)) ? cur : cur - tap_t'(1);
        return nxt;
    endfunction

endpackage

// File: rtl/pot_cmd_gate.sv
module pot_cmd_gate
    import potbank_pkg::*;
(
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] strap,
    input  logic              busy,
    input  logic              wp_n,
    input  logic              recall,
    output logic              accept,
    output logic              refuse,
    output logic              prog_start
);
    logic hit;
    logic slot_wr;
    logic blocked;

    always_comb begin
        hit        = cmd.valid && (cmd.addr == strap);
        slot_wr    = writes_slot(cmd.op);
        blocked    = recall || busy || (slot_wr && !wp_n);
        accept     = hit && !blocked;
        refuse     = hit && blocked;
        prog_start = accept && slot_wr;
    end
endmodule

// File: rtl/pot_prog_timer.sv
module pot_prog_timer #(
    parameter int PROG_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                   remain <= '0;
        else if (start)            remain <= CNT_LOAD;
        else if (remain != '0)     remain <= remain - CNT_W'(1);
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/pot_tap_decoder.sv
module pot_tap_decoder
    import potbank_pkg::*;
(
    input  tap_t                wiper,
    output logic [NUM_TAPS-1:0] onehot
);
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        assign onehot[t] = (wiper == tap_t'(t));
    end
endmodule

// File: rtl/pot_channel.sv
module pot_channel
    import potbank_pkg::*;
#(
    parameter tap_t INIT_SETTING = tap_t'(32)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  op_e                 op,
    input  logic [SLOT_W-1:0]   idx,
    input  tap_t                data,
    input  logic                recall,
    output tap_t                peek,
    output logic [NUM_TAPS-1:0] taps
);
    tap_t wiper;
    tap_t slot [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper <= INIT_SETTING;
            for (int i = 0; i < NUM_SLOTS; i++) slot[i] <= INIT_SETTING;
        end else begin
            if (sel) begin
                unique case (op)
                    OP_WR_WIPER: wiper     <= data;
                    OP_WR_SLOT:  slot[idx] <= data;
                    OP_LOAD:     wiper     <= slot[idx];
                    OP_STORE:    slot[idx] <= wiper;
                    OP_UP:       wiper     <= step_tap(wiper, 1'b1);
                    OP_DOWN:     wiper     <= step_tap(wiper, 1'b0);
                    default:     ;
                endcase
            end
            if (recall) wiper <= slot[0];
        end
    end

    assign peek = (op == OP_RD_WIPER) ? wiper : slot[idx];

    pot_tap_decoder u_dec (
        .wiper  (wiper),
        .onehot (taps)
    );
endmodule

// File: rtl/potbank_core.sv
module potbank_core
    import potbank_pkg::*;
#(
    parameter int   PROG_CYCLES  = 500000,
    parameter tap_t INIT_SETTING = tap_t'(32)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          strap,
    input  logic                       wp_n,
    input  logic                       recall,
    input  logic                       cmd_valid,
    input  logic [ADDR_W-1:0]          cmd_addr,
    input  logic [OP_W-1:0]            cmd_op,
    input  logic [CH_W-1:0]            cmd_chan,
    input  logic [SLOT_W-1:0]          cmd_idx,
    input  logic [TAP_W-1:0]           cmd_data,
    output logic                       ack,
    output logic                       reject,
    output logic                       rd_valid,
    output logic [TAP_W-1:0]           rd_data,
    output logic                       busy,
    output logic [NUM_CH*NUM_TAPS-1:0] tap_sel
);
    cmd_t cmd;
    logic accept;
    logic refuse;
    logic prog_start;
    tap_t peek [NUM_CH];

    always_comb begin
        cmd.valid = cmd_valid;
        cmd.addr  = cmd_addr;
        cmd.op    = op_e'(cmd_op);
        cmd.chan  = cmd_chan;
        cmd.idx   = cmd_idx;
        cmd.data  = cmd_data;
    end

    pot_cmd_gate u_gate (
        .cmd        (cmd),
        .strap      (strap),
        .busy       (busy),
        .wp_n       (wp_n),
        .recall     (recall),
        .accept     (accept),
        .refuse     (refuse),
        .prog_start (prog_start)
    );

    pot_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (prog_start),
        .busy  (busy)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pot_channel #(.INIT_SETTING(INIT_SETTING)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .sel    (accept && (cmd.chan == CH_W'(c))),
            .op     (cmd.op),
            .idx    (cmd.idx),
            .data   (cmd.data),
            .recall (recall),
            .peek   (peek[c]),
            .taps   (tap_sel[c*NUM_TAPS +: NUM_TAPS])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack      <= 1'b0;
            reject   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            ack      <= accept;
            reject   <= refuse;
            rd_valid <= accept && is_read(cmd.op);
            if (accept && is_read(cmd.op)) rd_data <= peek[cmd.chan];
        end
    end
endmodule

// File: rtl/potbank_chk.sv
module potbank_chk
    import potbank_pkg::*;
#(
    parameter int PROG_CYCLES = 500000
) (
    input logic                       clk,
    input logic                       rst,
    input logic [ADDR_W-1:0]          strap,
    input logic                       wp_n,
    input logic                       recall,
    input logic                       cmd_valid,
    input logic [ADDR_W-1:0]          cmd_addr,
    input logic [OP_W-1:0]            cmd_op,
    input logic                       ack,
    input logic                       reject,
    input logic                       rd_valid,
    input logic                       busy,
    input logic [NUM_CH*NUM_TAPS-1:0] tap_sel
);
    logic [31:0] busy_run;
    logic        hit;
    logic        slot_wr;

    assign hit     = cmd_valid && (cmd_addr == strap);
    assign slot_wr = (cmd_op == 3'd3) || (cmd_op == 3'd5);

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 32'd1;
        else           busy_run <= '0;
    end

    AST_ACK_REJ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ack && reject)); // R11

    AST_TAP_ONEHOT_LO: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel[NUM_TAPS-1:0]) == 1); // R9

    AST_TAP_ONEHOT_HI: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel[2*NUM_TAPS-1:NUM_TAPS]) == 1); // R9

    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_addr != strap)) |=> (!ack && !reject && !rd_valid)); // R2

    AST_HIT_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        hit |=> (ack || reject)); // R11

    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (hit && busy) |=> reject); // R8

    AST_PROTECT_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (hit && !wp_n && slot_wr) |=> reject); // R5

    AST_RECALL_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (hit && recall) |=> reject); // R10

    AST_REJECT_NO_TAP_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (reject && !$past(recall)) |-> $stable(tap_sel)); // R8

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == PROG_CYCLES)); // R8
endmodule

bind potbank_core potbank_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .strap     (strap),
    .wp_n      (wp_n),
    .recall    (recall),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_op    (cmd_op),
    .ack       (ack),
    .reject    (reject),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .tap_sel   (tap_sel)
);

// File: tb/tb_potbank_core.sv
module tb_potbank_core;
    localparam int PROG  = 12;
    localparam int INIT  = 32;
    localparam logic [3:0] STRAP = 4'hA;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wp_n = 1'b1;
    logic         recall = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [3:0]   cmd_addr = '0;
    logic [2:0]   cmd_op = '0;
    logic [0:0]   cmd_chan = '0;
    logic [1:0]   cmd_idx = '0;
    logic [5:0]   cmd_data = '0;
    logic         ack, reject, rd_valid, busy;
    logic [5:0]   rd_data;
    logic [127:0] tap_sel;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;

    int  w [2];
    int  s [2][4];
    int  bcnt;
    bit  e_ack, e_rej, e_rv;
    int  e_rd;

    always #5 clk = ~clk;

    potbank_core #(.PROG_CYCLES(PROG), .INIT_SETTING(6'(INIT))) dut (
        .clk(clk), .rst(rst), .strap(STRAP), .wp_n(wp_n), .recall(recall),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_op(cmd_op),
        .cmd_chan(cmd_chan), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
        .ack(ack), .reject(reject), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .tap_sel(tap_sel)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model(input bit v, input logic [3:0] a, input int op, input int ch,
                         input int idx, input int d, input bit wp, input bit rc);
        bit match = v && (a == STRAP);
        bit rw = (op == 3) || (op == 5);
        int nb = (bcnt > 0) ? bcnt - 1 : 0;
        e_ack = 0; e_rej = 0; e_rv = 0;
        if (match) begin
            if (rc || bcnt > 0 || (rw && !wp)) e_rej = 1;
            else begin
                e_ack = 1;
                case (op)
                    0: begin e_rv = 1; e_rd = w[ch]; end
                    1: w[ch] = d;
                    2: begin e_rv = 1; e_rd = s[ch][idx]; end
                    3: s[ch][idx] = d;
                    4: w[ch] = s[ch][idx];
                    5: s[ch][idx] = w[ch];
                    6: if (w[ch] < 63) w[ch]++;
                    default: if (w[ch] > 0) w[ch]--;
                endcase
                if (rw) nb = PROG;
            end
        end
        if (rc) for (int c = 0; c < 2; c++) w[c] = s[c][0];
        bcnt = nb;
    endtask

    task automatic cyc(input string tag, input bit v, input logic [3:0] a, input int op,
                       input int ch, input int idx, input int d, input bit rc);
        logic [127:0] et;
        @(negedge clk);
        cmd_valid = v; cmd_addr = a; cmd_op = 3'(op); cmd_chan = 1'(ch);
        cmd_idx = 2'(idx); cmd_data = 6'(d); recall = rc;
        model(v, a, op, ch, idx, d, wp_n, rc);
        @(posedge clk);
        #2;
        cmd_valid = 0; recall = 0;
        et = '0;
        et[w[0]] = 1'b1;
        et[64 + w[1]] = 1'b1;
        check("R11", {tag, " ack"}, ack, e_ack);
        check("R11", {tag, " reject"}, reject, e_rej);
        check(tag, "rd_valid", rd_valid, e_rv);
        if (e_rv) check(tag, "rd_data", rd_data, e_rd);
        check("R8", {tag, " busy"}, busy, bcnt > 0);
        checks++;
        if (tap_sel !== et) begin
            errors++;
            $display("FAIL R9 %s tap_sel: actual=%h expected=%h", tag, tap_sel, et);
        end
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, STRAP, 0, 0, 0, 0, 0);
    endtask

    task automatic drain(input string tag);
        while (bcnt > 0) idle(tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            w[c] = INIT;
            for (int i = 0; i < 4; i++) s[c][i] = INIT;
        end
        bcnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: reset state
        #1;
        check("R1", "busy", busy, 0);
        check("R1", "ack", ack, 0);
        check("R1", "tap0", tap_sel[INIT], 1);
        check("R1", "tap1", tap_sel[64+INIT], 1);
        idle("R1");
        cyc("R1", 1, STRAP, 0, 1, 0, 0, 0);
        cyc("R1", 1, STRAP, 2, 0, 3, 0, 0);

        // R3: wiper write/read
        cyc("R3", 1, STRAP, 1, 0, 0, 10, 0);
        cyc("R3", 1, STRAP, 0, 0, 0, 0, 0);
        cyc("R3", 1, STRAP, 1, 1, 0, 63, 0);
        cyc("R3", 1, STRAP, 0, 1, 0, 0, 0);

        // R2: wrong address is silent
        cyc("R2", 1, 4'h5, 1, 0, 0, 50, 0);
        cyc("R2", 1, 4'hB, 3, 0, 0, 7, 0);
        cyc("R2", 1, STRAP, 0, 0, 0, 0, 0);
        cyc("R2", 1, STRAP, 2, 0, 0, 0, 0);

        // R4 + R8: slot write starts programming window
        cyc("R4", 1, STRAP, 3, 1, 2, 40, 0);
        cyc("R8", 1, STRAP, 1, 0, 0, 1, 0);
        cyc("R8", 1, STRAP, 2, 1, 2, 0, 0);
        cyc("R8", 1, 4'h3, 1, 0, 0, 2, 0);
        while (bcnt > 1) idle("R8");
        cyc("R8", 1, STRAP, 1, 0, 0, 9, 0);   // last busy cycle
        cyc("R8", 1, STRAP, 1, 0, 0, 9, 0);   // first free cycle
        cyc("R4", 1, STRAP, 2, 1, 2, 0, 0);

        // R5: write protect
        wp_n = 0;
        cyc("R5", 1, STRAP, 3, 0, 1, 17, 0);
        cyc("R5", 1, STRAP, 5, 0, 2, 0, 0);
        cyc("R5", 1, STRAP, 1, 0, 0, 21, 0);
        cyc("R5", 1, STRAP, 2, 0, 1, 0, 0);
        cyc("R5", 1, STRAP, 2, 0, 2, 0, 0);
        wp_n = 1;

        // R6: transfers
        cyc("R6", 1, STRAP, 5, 0, 1, 0, 0);
        drain("R6");
        cyc("R6", 1, STRAP, 2, 0, 1, 0, 0);
        cyc("R6", 1, STRAP, 4, 1, 2, 0, 0);
        cyc("R6", 1, STRAP, 0, 1, 0, 0, 0);

        // R7: saturating steps
        cyc("R7", 1, STRAP, 1, 0, 0, 62, 0);
        cyc("R7", 1, STRAP, 6, 0, 0, 0, 0);
        cyc("R7", 1, STRAP, 6, 0, 0, 0, 0);
        cyc("R7", 1, STRAP, 6, 0, 0, 0, 0);
        cyc("R7", 1, STRAP, 1, 1, 0, 1, 0);
        cyc("R7", 1, STRAP, 7, 1, 0, 0, 0);
        cyc("R7", 1, STRAP, 7, 1, 0, 0, 0);
        cyc("R7", 1, STRAP, 0, 1, 0, 0, 0);

        // R10: recall, alone and colliding with a command
        cyc("R10", 1, STRAP, 3, 0, 0, 11, 0);
        drain("R10");
        cyc("R10", 0, STRAP, 0, 0, 0, 0, 1);
        cyc("R10", 1, STRAP, 0, 0, 0, 0, 0);
        cyc("R10", 1, STRAP, 1, 1, 0, 5, 0);
        cyc("R10", 1, STRAP, 1, 1, 0, 44, 1);
        cyc("R10", 1, STRAP, 0, 1, 0, 0, 0);
        cyc("R10", 1, STRAP, 2, 0, 0, 0, 0);
        idle("R10");

        done = 1;
        finish_run();
    end
endmodule